// File: doc/BRIEF.md
# Texture Coordinate Wrap Unit

This block takes a pair of signed integer texel coordinates and folds each one into the usable area of a texture before any memory address is formed. The horizontal (U) and vertical (V) axes each have their own 2-bit addressing mode, so a texture can tile in one direction and stop at its edge in the other. Besides the power-of-two size, each axis carries two 10-bit operands. The region modes interpret them either as lower and upper limits, or as an AND mask and an OR pattern that pick a repeating sub-window out of a larger texture.

The texture size for each axis is given as a 4-bit base-2 exponent. Any exponent above 10 is treated as 10, so the largest area is 1024 texels per side. One register stage holds the results. A result is captured only in cycles where the input strobe is high, and the output strobe follows the input strobe one cycle later.

Top module: `tex_wrap_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and both `out_u` and `out_v` are 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge. A result sampled with `in_valid` = 1 appears on `out_u`/`out_v` after that edge.
- R3: When `in_valid` is 0 at an edge, `out_u` and `out_v` keep their previous values, whatever the other inputs do.
- R4: Mode 0 (repeat) outputs the coordinate modulo 2^L, where L is the effective size exponent. Negative coordinates wrap the same way, so for example -1 gives 2^L-1.
- R5: Mode 1 (clamp) outputs 0 for any negative coordinate. It outputs 2^L-1 for any coordinate above 2^L-1, and the coordinate itself otherwise.
- R6: Mode 2 (region clamp) raises a coordinate below the first operand (min) to min. It then lowers any value above the second operand (max) to max. The max limit is applied last, so when min > max the output is max.
- R7: Mode 3 (region repeat) outputs (low 10 bits of the coordinate AND first operand) OR second operand.
- R8: The U result depends only on `in_u`, `in_log_w`, `in_mode_u`, `in_min_u` and `in_max_u`. The V result depends only on the V-side inputs. Different modes may be active on the two axes in the same cycle.
- R9: The effective size exponent L is min(exponent input, 10). Exponents 11 to 15 behave exactly like 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input coordinates are valid this cycle |
| in_u | input | 12 | Signed U coordinate |
| in_v | input | 12 | Signed V coordinate |
| in_log_w | input | 4 | Base-2 exponent of texture width |
| in_log_h | input | 4 | Base-2 exponent of texture height |
| in_mode_u | input | 2 | U mode: 0 repeat, 1 clamp, 2 region clamp, 3 region repeat |
| in_mode_v | input | 2 | V mode, same encoding |
| in_min_u | input | 10 | U first operand (lower limit or AND mask) |
| in_max_u | input | 10 | U second operand (upper limit or OR pattern) |
| in_min_v | input | 10 | V first operand |
| in_max_v | input | 10 | V second operand |
| out_valid | output | 1 | Registered result strobe |
| out_u | output | 10 | Wrapped U coordinate |
| out_v | output | 10 | Wrapped V coordinate |

## Verification
Every mode is swept against every size exponent from 0 to 11. The coordinates cover the whole signed 12-bit range in steps that land on both negative and oversized values. This separates true modulo wrapping from sign-blind masking, and shows whether clamping treats negative inputs as huge positive ones. The V axis runs a different mode, a different exponent and a mirrored coordinate in the same cycle, which exposes any sharing or swapping between the axes. One pass puts the region limits in reversed order, to fix which limit wins. A separate sequence drops the strobe while changing every input, to show that the stored result is held.

// File: rtl/tex_wrap_pkg.sv
package tex_wrap_pkg;

    typedef enum logic [1:0] {
        WRAP_REPEAT  = 2'd0,
        WRAP_CLAMP   = 2'd1,
        WRAP_RCLAMP  = 2'd2,
        WRAP_RREPEAT = 2'd3
    } wrap_mode_e;

    localparam int AXES = 2;

endpackage

// File: rtl/tex_wrap_size.sv
module tex_wrap_size #(
    parameter int LOG_W   = 4,
    parameter int FIELD_W = 10
) (
    input  logic [LOG_W-1:0]   log_size,
    output logic [FIELD_W-1:0] size_mask
);
    localparam logic [LOG_W-1:0] LOG_MAX = LOG_W'(FIELD_W);

    logic [LOG_W-1:0] log_sat;

    always_comb begin
        log_sat   = (log_size > LOG_MAX) ? LOG_MAX : log_size;
        // shifting by the full width yields zero, so the mask becomes all ones
        size_mask = ~({FIELD_W{1'b1}} << log_sat);
    end
endmodule

// File: rtl/tex_wrap_axis.sv
module tex_wrap_axis
    import tex_wrap_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int LOG_W   = 4,
    parameter int FIELD_W = 10
) (
    input  logic signed [COORD_W-1:0] coord,
    input  logic [LOG_W-1:0]          log_size,
    input  logic [1:0]                mode,
    input  logic [FIELD_W-1:0]        op_lo,
    input  logic [FIELD_W-1:0]        op_hi,
    output logic [FIELD_W-1:0]        wrapped
);
    localparam int EXT = COORD_W - FIELD_W;

    logic [FIELD_W-1:0]        size_mask;
    logic signed [COORD_W-1:0] mask_ext;
    logic signed [COORD_W-1:0] lo_ext;
    logic signed [COORD_W-1:0] hi_ext;
    logic signed [COORD_W-1:0] raised;

    tex_wrap_size #(.LOG_W(LOG_W), .FIELD_W(FIELD_W)) u_size (
        .log_size  (log_size),
        .size_mask (size_mask)
    );

    assign mask_ext = {{EXT{1'b0}}, size_mask};
    assign lo_ext   = {{EXT{1'b0}}, op_lo};
    assign hi_ext   = {{EXT{1'b0}}, op_hi};

    always_comb begin
        raised  = (coord < lo_ext) ? lo_ext : coord;
        wrapped = '0;
        case (wrap_mode_e'(mode))
            WRAP_REPEAT:  wrapped = coord[FIELD_W-1:0] & size_mask;
            WRAP_CLAMP: begin
                if (coord[COORD_W-1])      wrapped = '0;
                else if (coord > mask_ext) wrapped = size_mask;
                else                       wrapped = coord[FIELD_W-1:0];
            end
            WRAP_RCLAMP:  wrapped = (raised > hi_ext) ? op_hi : raised[FIELD_W-1:0];
            WRAP_RREPEAT: wrapped = (coord[FIELD_W-1:0] & op_lo) | op_hi;
            default:      wrapped = '0;
        endcase
    end
endmodule

// File: rtl/tex_wrap_unit.sv
module tex_wrap_unit
    import tex_wrap_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int LOG_W   = 4,
    parameter int FIELD_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic signed [COORD_W-1:0] in_u,
    input  logic signed [COORD_W-1:0] in_v,
    input  logic [LOG_W-1:0]          in_log_w,
    input  logic [LOG_W-1:0]          in_log_h,
    input  logic [1:0]                in_mode_u,
    input  logic [1:0]                in_mode_v,
    input  logic [FIELD_W-1:0]        in_min_u,
    input  logic [FIELD_W-1:0]        in_max_u,
    input  logic [FIELD_W-1:0]        in_min_v,
    input  logic [FIELD_W-1:0]        in_max_v,
    output logic                      out_valid,
    output logic [FIELD_W-1:0]        out_u,
    output logic [FIELD_W-1:0]        out_v
);
    typedef struct packed {
        logic               vld;
        logic [FIELD_W-1:0] u;
        logic [FIELD_W-1:0] v;
    } stage_t;

    logic signed [COORD_W-1:0] coord_a [AXES];
    logic [LOG_W-1:0]          log_a   [AXES];
    logic [1:0]                mode_a  [AXES];
    logic [FIELD_W-1:0]        lo_a    [AXES];
    logic [FIELD_W-1:0]        hi_a    [AXES];
    logic [FIELD_W-1:0]        res_a   [AXES];

    assign coord_a[0] = in_u;      assign coord_a[1] = in_v;
    assign log_a[0]   = in_log_w;  assign log_a[1]   = in_log_h;
    assign mode_a[0]  = in_mode_u; assign mode_a[1]  = in_mode_v;
    assign lo_a[0]    = in_min_u;  assign lo_a[1]    = in_min_v;
    assign hi_a[0]    = in_max_u;  assign hi_a[1]    = in_max_v;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        tex_wrap_axis #(
            .COORD_W (COORD_W),
            .LOG_W   (LOG_W),
            .FIELD_W (FIELD_W)
        ) u_axis (
            .coord    (coord_a[g]),
            .log_size (log_a[g]),
            .mode     (mode_a[g]),
            .op_lo    (lo_a[g]),
            .op_hi    (hi_a[g]),
            .wrapped  (res_a[g])
        );
    end

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.u = res_a[0];
            stage_d.v = res_a[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign out_u     = stage_q.u;
    assign out_v     = stage_q.v;
endmodule

// File: rtl/tex_wrap_unit_chk.sv
module tex_wrap_unit_chk #(
    parameter int COORD_W = 12,
    parameter int LOG_W   = 4,
    parameter int FIELD_W = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic signed [COORD_W-1:0] in_u,
    input logic [LOG_W-1:0]          in_log_w,
    input logic [LOG_W-1:0]          in_log_h,
    input logic [1:0]                in_mode_u,
    input logic [1:0]                in_mode_v,
    input logic [FIELD_W-1:0]        in_min_u,
    input logic [FIELD_W-1:0]        in_max_u,
    input logic                      out_valid,
    input logic [FIELD_W-1:0]        out_u,
    input logic [FIELD_W-1:0]        out_v
);
    int lim_u, lim_v;
    always_comb begin
        lim_u = 1 << ((int'(in_log_w) > FIELD_W) ? FIELD_W : int'(in_log_w));
        lim_v = 1 << ((int'(in_log_h) > FIELD_W) ? FIELD_W : int'(in_log_h));
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_u) && $stable(out_v)));
    p_repeat_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode_u == 2'd0) |=> (int'(out_u) < $past(lim_u)));
    p_clamp_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode_u == 2'd1) |=> (int'(out_u) < $past(lim_u)));
    p_clamp_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode_u == 2'd1 && in_u < 0) |=> (out_u == '0));
    p_clamp_range_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode_v == 2'd1) |=> (int'(out_v) < $past(lim_v)));
    p_region_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode_u == 2'd2 && in_min_u <= in_max_u)
        |=> (out_u >= $past(in_min_u) && out_u <= $past(in_max_u)));
    p_region_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode_u == 2'd3)
        |=> (((out_u & $past(in_max_u)) == $past(in_max_u)) &&
             ((out_u & ~($past(in_min_u) | $past(in_max_u))) == '0)));
endmodule

bind tex_wrap_unit tex_wrap_unit_chk #(
    .COORD_W (COORD_W),
    .LOG_W   (LOG_W),
    .FIELD_W (FIELD_W)
) u_chk (.*);

// File: tb/tex_wrap_unit_test.sv
module tex_wrap_unit_test;
    localparam int COORD_W = 12;
    localparam int LOG_W   = 4;
    localparam int FIELD_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [COORD_W-1:0] in_u = '0, in_v = '0;
    logic [LOG_W-1:0] in_log_w = '0, in_log_h = '0;
    logic [1:0] in_mode_u = '0, in_mode_v = '0;
    logic [FIELD_W-1:0] in_min_u = '0, in_max_u = '0, in_min_v = '0, in_max_v = '0;
    logic out_valid;
    logic [FIELD_W-1:0] out_u, out_v;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tex_wrap_unit #(.COORD_W(COORD_W), .LOG_W(LOG_W), .FIELD_W(FIELD_W)) uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .in_u (in_u), .in_v (in_v), .in_log_w (in_log_w), .in_log_h (in_log_h),
        .in_mode_u (in_mode_u), .in_mode_v (in_mode_v),
        .in_min_u (in_min_u), .in_max_u (in_max_u),
        .in_min_v (in_min_v), .in_max_v (in_max_v),
        .out_valid (out_valid), .out_u (out_u), .out_v (out_v)
    );

    function automatic int model(int c, int mode, int lg, int mn, int mx);
        int l, sz, r;
        l  = (lg > 10) ? 10 : lg;
        sz = 1 << l;
        case (mode)
            0: r = ((c % sz) + sz) % sz;
            1: r = (c < 0) ? 0 : ((c > sz - 1) ? sz - 1 : c);
            2: begin
                r = (c < mn) ? mn : c;
                if (r > mx) r = mx;
            end
            default: r = ((c & 1023) & mn) | mx;
        endcase
        return r;
    endfunction

    function automatic string tag_of(int mode, int lg);
        if (lg > 10) return "R9";
        case (mode)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(int cu, int mu, int lu, int nu, int xu,
                           int cv, int mv, int lv, int nv, int xv);
        @(negedge clk);
        in_valid  = 1'b1;
        in_u      = COORD_W'(cu);   in_v      = COORD_W'(cv);
        in_mode_u = 2'(mu);         in_mode_v = 2'(mv);
        in_log_w  = LOG_W'(lu);     in_log_h  = LOG_W'(lv);
        in_min_u  = FIELD_W'(nu);   in_max_u  = FIELD_W'(xu);
        in_min_v  = FIELD_W'(nv);   in_max_v  = FIELD_W'(xv);
        @(negedge clk);
        check(tag_of(mu, lu), int'(out_u), model(cu, mu, lu, nu, xu));
        check("R8", int'(out_v), model(cv, mv, lv, nv, xv));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_u), 0);
        check("R1", int'(out_v), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_valid), 0);

        // latency of the strobe (R2)
        in_valid = 1'b1; in_u = 12'sd5; in_mode_u = 2'd0; in_log_w = 4'd3;
        @(negedge clk);
        check("R2", int'(out_valid), 1);
        check("R2", int'(out_u), 5);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", int'(out_valid), 0);

        // hold while strobe low (R3)
        in_u = -12'sd7; in_v = 12'sd300; in_mode_u = 2'd1; in_mode_v = 2'd3;
        in_min_v = 10'h3ff; in_max_v = 10'h155; in_log_h = 4'd9;
        repeat (2) @(negedge clk);
        check("R3", int'(out_u), 5);
        check("R3", int'(out_v), 0);
        check("R3", int'(out_valid), 0);

        // near-exhaustive sweep
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 12; l++) begin
                for (int c = -2048; c < 2048; c += 37) begin
                    int mn, mx;
                    mn = (l * 53) % 900;
                    mx = mn + 60 + l;
                    if (l == 11) begin
                        int t;
                        t = mn; mn = mx; mx = t;   // reversed limits (R6)
                    end
                    run_vec(c, m, l, mn, mx, -c - 1, 3 - m, 11 - l, mx & 511, mn);
                end
            end
        end

        // explicit corners
        run_vec(-1, 0, 4, 0, 0, 16, 0, 4, 0, 0);          // R4: -1 -> 15, 16 -> 0
        run_vec(2047, 1, 15, 0, 0, -2048, 1, 10, 0, 0);   // R9, R5
        run_vec(3, 2, 0, 200, 100, 150, 2, 0, 100, 200);  // R6 reversed and in range
        run_vec(-1, 3, 0, 10'h0f0, 10'h00a, 0, 3, 0, 10'h3ff, 0); // R7

        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule